// File: doc/BRIEF.md
# Memory-Based 4x4 Matrix Multiplier

This block multiplies two 4x4 matrices of unsigned 4-bit elements. The matrices are kept in two small single-port memories, and the block writes the 4x4 product into a third single-port memory, one byte per element. A host loads the two operand memories through a shared address/data port while the block is idle. It then pulses `start`, waits for the one-cycle `done` pulse, and reads the products back through the same port.

Inside, a controller state machine and a datapath are kept apart. The state machine walks the output elements in row-major order. It issues the memory addresses, the accumulator controls and the result write strobe. The datapath holds the current operand row, picks out the two elements that each step needs, multiplies them and adds the product into an accumulator. Every run takes the same number of cycles, whatever the data.

Top module: `matmul4_mem`

## Requirements
- R1: After reset `done` is low, and it stays low for as long as `start` is not asserted.
- R2: Each operand memory word holds one matrix row of four 4-bit unsigned elements. Element m (column index m) sits in bits 4m+3:4m. The first operand uses word address i for row i, and the second operand uses word address k for row k.
- R3: The stored result for row i, column j is the sum over k of A[i][k]*B[k][j], reduced modulo 256. For example, all elements equal to 15 give 900 mod 256 = 132.
- R4: The result for row i, column j is stored at result address 4*i + j.
- R5: `done` is high for exactly one cycle. Counting the rising edge that samples `start` as edge 1, `done` is first high after edge 154.
- R6: While the block is idle, the host reads a result by presenting its address on `host_addr`. The byte appears on `host_rdata` after the next rising edge.
- R7: While a run is in progress, host writes (`host_we`) are ignored. Neither that run's results nor the contents of the operand memories change.
- R8: A `start` pulse during a run is ignored. That run still produces exactly one `done` at the normal time, and no further `done` follows.
- R9: After `done` the block is idle again. A `start` in the following cycle begins a fresh run that gives correct results, with no carry-over between elements or between runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when sampled high while idle |
| done | output | 1 | One-cycle pulse when the last result has been written |
| host_we | input | 1 | Host write strobe for an operand memory, acted on only while idle |
| host_sel | input | 1 | Operand memory select: 0 = first operand (A), 1 = second operand (B) |
| host_addr | input | 4 | Host address: row index in bits 1:0 for operand writes; result address for reads |
| host_wdata | input | 16 | Packed operand row to write |
| host_rdata | output | 8 | Result byte read from the address presented in the previous cycle |

## Verification
Most faults in the counters, the element selection or the accumulator control stay hidden until the run ends. They then show up as wrong bytes in specific result cells: a stuck column counter spoils a whole column, and a missing accumulator clear spoils every element after the first. These cells can be read back only after `done`, so the bench compares all sixteen cells against independently computed products for several patterns. A wrong state sequence shows up sooner and more directly: it moves `done` away from edge 154 or lengthens the pulse. The bench measures both on every run, and the checker watches them edge by edge together with the result write order.

// File: rtl/mm_pkg.sv
// Shared types for the memory-based matrix multiplier.
// Assumes: nothing beyond standard SystemVerilog.
package mm_pkg;

    // Controller states; one element step is FETCH followed by MAC.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SETUP    = 3'd1,
        ST_ROW_ADDR = 3'd2,
        ST_ROW_CAP  = 3'd3,
        ST_FETCH    = 3'd4,
        ST_MAC      = 3'd5,
        ST_WRITE    = 3'd6,
        ST_FINISH   = 3'd7
    } mm_state_e;

endpackage

// File: rtl/mm_spram.sv
// Single-port synchronous memory: one access per cycle, write or read.
// Assumes: registered read data, valid the cycle after the address; old
// data is returned on a write cycle. Contents are not reset.
module mm_spram #(
    parameter int AW = 2,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    // Purpose: perform the single access of this cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end
endmodule

// File: rtl/mm_ctrl.sv
// Controller: walks output elements row-major and sequences memory reads,
// accumulation and result writes with a data-independent cycle count.
// Assumes: N >= 2; memories have one-cycle registered read latency.
module mm_ctrl
    import mm_pkg::*;
#(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           busy,
    output logic           done,
    output logic           row_ld,
    output logic           acc_clr,
    output logic           acc_en,
    output logic           c_we,
    output logic [RAW-1:0] a_addr,
    output logic [RAW-1:0] b_addr,
    output logic [CAW-1:0] c_addr,
    output logic [RAW-1:0] k_idx,
    output logic [RAW-1:0] j_idx
);
    localparam int RAW = $clog2(N);
    localparam int CAW = $clog2(N * N);
    localparam logic [RAW-1:0] LAST = RAW'(N - 1);

    mm_state_e      state_q;
    logic [RAW-1:0] i_q;
    logic [RAW-1:0] j_q;
    logic [RAW-1:0] k_q;

    // Purpose: advance the state and the row/column/term counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            i_q     <= '0;
            j_q     <= '0;
            k_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    i_q     <= '0;
                    j_q     <= '0;
                    k_q     <= '0;
                    state_q <= ST_ROW_ADDR;
                end
                ST_ROW_ADDR: begin
                    state_q <= ST_ROW_CAP;
                end
                ST_ROW_CAP: begin
                    k_q     <= '0;
                    state_q <= ST_FETCH;
                end
                ST_FETCH: begin
                    state_q <= ST_MAC;
                end
                ST_MAC: begin
                    if (k_q == LAST) begin
                        state_q <= ST_WRITE;
                    end else begin
                        k_q     <= k_q + 1'b1;
                        state_q <= ST_FETCH;
                    end
                end
                ST_WRITE: begin
                    k_q <= '0;
                    if (j_q == LAST) begin
                        j_q <= '0;
                        if (i_q == LAST) begin
                            state_q <= ST_FINISH;
                        end else begin
                            i_q     <= i_q + 1'b1;
                            state_q <= ST_ROW_ADDR;
                        end
                    end else begin
                        j_q     <= j_q + 1'b1;
                        state_q <= ST_FETCH;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Purpose: decode control strobes and addresses from the current state.
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_FINISH);
        row_ld  = (state_q == ST_ROW_CAP);
        acc_clr = (state_q == ST_SETUP) || (state_q == ST_WRITE);
        acc_en  = (state_q == ST_MAC);
        c_we    = (state_q == ST_WRITE);
        a_addr  = i_q;
        b_addr  = k_q;
        c_addr  = CAW'(int'(i_q) * N + int'(j_q));
        k_idx   = k_q;
        j_idx   = j_q;
    end
endmodule

// File: rtl/mm_datapath.sv
// Datapath: holds the current row of A, selects A[i][k] and B[k][j] from
// the packed words, multiplies and accumulates; presents the low bits.
// Assumes: b_rdata is the word of row k during the accumulate cycle.
module mm_datapath #(
    parameter int N  = 4,
    parameter int EW = 4,
    parameter int OW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           row_ld,
    input  logic           acc_clr,
    input  logic           acc_en,
    input  logic [RW-1:0]  a_rdata,
    input  logic [RW-1:0]  b_rdata,
    input  logic [RAW-1:0] k_idx,
    input  logic [RAW-1:0] j_idx,
    output logic [OW-1:0]  c_wdata
);
    localparam int RW   = N * EW;
    localparam int RAW  = $clog2(N);
    localparam int PW   = 2 * EW;
    localparam int SUMW = PW + $clog2(N);
    localparam int ACCW = (SUMW > OW) ? SUMW : OW;

    logic [RW-1:0]   row_q;
    logic [EW-1:0]   a_el [N];
    logic [EW-1:0]   b_el [N];
    logic [PW-1:0]   prod;
    logic [ACCW-1:0] acc_q;

    // Unpack both row words into element lanes.
    for (genvar m = 0; m < N; m++) begin : g_lane
        assign a_el[m] = row_q[m*EW +: EW];
        assign b_el[m] = b_rdata[m*EW +: EW];
    end

    assign prod    = PW'(a_el[k_idx]) * PW'(b_el[j_idx]);
    assign c_wdata = acc_q[OW-1:0];

    // Purpose: capture the operand row for the current output row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (row_ld) begin
            row_q <= a_rdata;
        end
    end

    // Purpose: clear or accumulate the running dot product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (acc_clr) begin
            acc_q <= '0;
        end else if (acc_en) begin
            acc_q <= acc_q + ACCW'(prod);
        end
    end
endmodule

// File: rtl/matmul4_mem.sv
// Top: three single-port memories, the controller and the datapath. The
// host port reaches the memories only while the controller is idle.
// Assumes: host drives host_* synchronously to clk.
module matmul4_mem
    import mm_pkg::*;
#(
    parameter int N  = 4,
    parameter int EW = 4,
    parameter int OW = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    output logic                         done,
    input  logic                         host_we,
    input  logic                         host_sel,
    input  logic [$clog2(N*N)-1:0]       host_addr,
    input  logic [N*EW-1:0]              host_wdata,
    output logic [OW-1:0]                host_rdata
);
    localparam int RW  = N * EW;
    localparam int RAW = $clog2(N);
    localparam int CAW = $clog2(N * N);

    logic           busy;
    logic           row_ld;
    logic           acc_clr;
    logic           acc_en;
    logic           c_we;
    logic [RAW-1:0] ctl_a_addr;
    logic [RAW-1:0] ctl_b_addr;
    logic [CAW-1:0] c_addr;
    logic [RAW-1:0] k_idx;
    logic [RAW-1:0] j_idx;
    logic [RW-1:0]  a_rdata;
    logic [RW-1:0]  b_rdata;
    logic [OW-1:0]  c_wdata;
    logic           a_we;
    logic           b_we;
    logic [RAW-1:0] a_addr_m;
    logic [RAW-1:0] b_addr_m;
    logic [CAW-1:0] c_addr_m;

    // Purpose: give the memories to the host while idle, else to the controller.
    always_comb begin
        a_we     = host_we && !host_sel && !busy;
        b_we     = host_we &&  host_sel && !busy;
        a_addr_m = busy ? ctl_a_addr : host_addr[RAW-1:0];
        b_addr_m = busy ? ctl_b_addr : host_addr[RAW-1:0];
        c_addr_m = busy ? c_addr     : host_addr;
    end

    mm_ctrl #(.N(N)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .done    (done),
        .row_ld  (row_ld),
        .acc_clr (acc_clr),
        .acc_en  (acc_en),
        .c_we    (c_we),
        .a_addr  (ctl_a_addr),
        .b_addr  (ctl_b_addr),
        .c_addr  (c_addr),
        .k_idx   (k_idx),
        .j_idx   (j_idx)
    );

    mm_datapath #(.N(N), .EW(EW), .OW(OW)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_ld  (row_ld),
        .acc_clr (acc_clr),
        .acc_en  (acc_en),
        .a_rdata (a_rdata),
        .b_rdata (b_rdata),
        .k_idx   (k_idx),
        .j_idx   (j_idx),
        .c_wdata (c_wdata)
    );

    mm_spram #(.AW(RAW), .DW(RW)) u_mem_a (
        .clk   (clk),
        .we    (a_we),
        .addr  (a_addr_m),
        .wdata (host_wdata),
        .rdata (a_rdata)
    );

    mm_spram #(.AW(RAW), .DW(RW)) u_mem_b (
        .clk   (clk),
        .we    (b_we),
        .addr  (b_addr_m),
        .wdata (host_wdata),
        .rdata (b_rdata)
    );

    mm_spram #(.AW(CAW), .DW(OW)) u_mem_c (
        .clk   (clk),
        .we    (c_we),
        .addr  (c_addr_m),
        .wdata (c_wdata),
        .rdata (host_rdata)
    );
endmodule

// File: rtl/mm_checker.sv
// Checker: run latency, done pulse shape, result write order and count.
// Assumes: bound to matmul4_mem; counters follow accepted starts.
module mm_checker #(
    parameter int N = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   done,
    input logic                   busy,
    input logic                   c_we,
    input logic [$clog2(N*N)-1:0] c_addr
);
    localparam int CAW  = $clog2(N * N);
    localparam int LAT  = 2 + N * (2 + N * (2 * N + 1));
    localparam int CNTW = 16;

    logic [CNTW-1:0] run_cnt;
    logic [CAW:0]    wr_cnt;

    // Purpose: count edges and result writes since the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            wr_cnt  <= '0;
        end else if (!busy && start) begin
            run_cnt <= CNTW'(1);
            wr_cnt  <= '0;
        end else begin
            if (busy) begin
                run_cnt <= run_cnt + 1'b1;
            end
            if (c_we) begin
                wr_cnt <= wr_cnt + 1'b1;
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (run_cnt == CNTW'(LAT))); // R5
    AST_ALL_RESULTS_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n) done |-> (wr_cnt == (CAW+1)'(N*N))); // R4
    AST_ROW_MAJOR_ORDER: assert property (@(posedge clk) disable iff (!rst_n) c_we |-> (c_addr == wr_cnt[CAW-1:0])); // R4
    AST_RUN_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy); // R8
    AST_NO_RESULT_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !c_we); // R7
endmodule

bind matmul4_mem mm_checker #(.N(N)) u_mm_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .busy   (busy),
    .c_we   (c_we),
    .c_addr (c_addr)
);

// File: tb/matmul4_mem_bench.sv
// Directed bench for matmul4_mem: one task per scenario, each self-checking.
module matmul4_mem_bench;
    localparam int LAT = 154;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        done;
    logic [7:0]  host_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int ma [4][4];
    int mb [4][4];

    always #5 clk = ~clk;

    matmul4_mem u_matmul4_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .done       (done),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic check_val(string req, string what, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // R2: row words packed with element m at bits 4m+3:4m.
    task automatic load_mats();
        for (int r = 0; r < 4; r++) begin
            for (int s = 0; s < 2; s++) begin
                logic [15:0] w;
                for (int m = 0; m < 4; m++) begin
                    w[m*4 +: 4] = (s == 0) ? 4'(ma[r][m]) : 4'(mb[r][m]);
                end
                @(negedge clk);
                host_we    = 1'b1;
                host_sel   = 1'(s);
                host_addr  = 4'(r);
                host_wdata = w;
            end
        end
        @(negedge clk);
        host_we = 1'b0;
    endtask

    function automatic int expect_c(int i, int j);
        int sum = 0;
        for (int k = 0; k < 4; k++) begin
            sum += ma[i][k] * mb[k][j];
        end
        return sum % 256;
    endfunction

    // R6: address at a negedge, data sampled after the next rising edge.
    task automatic check_results(string req);
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                host_addr = 4'(4 * i + j);
                @(negedge clk);
                check_val(req, $sformatf("C[%0d][%0d] (R4 addr %0d)", i, j, 4 * i + j),
                          int'(host_rdata), expect_c(i, j));
            end
        end
    endtask

    // R5: start at a negedge; count edges until done is seen; pulse width 1.
    task automatic run_matmul(bit poke_host, bit poke_start);
        int edges = 0;
        bit seen = 0;
        @(negedge clk);
        start = 1'b1;
        while (!seen && edges < 400) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            start   = 1'b0;
            host_we = 1'b0;
            if (poke_host && edges >= 3 && edges < 11) begin
                host_we    = 1'b1;
                host_sel   = (edges >= 7);
                host_addr  = 4'((edges - 3) % 4);
                host_wdata = 16'hFFFF;
            end
            if (poke_start && edges == 40) begin
                start = 1'b1;
            end
            if (done) begin
                seen = 1;
            end
        end
        host_we = 1'b0;
        start   = 1'b0;
        check_val("R5", "edges to done", edges, LAT);
        @(negedge clk);
        check_val("R5", "done after one cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_val("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        begin
            int hits = 0;
            for (int c = 0; c < 200; c++) begin
                @(negedge clk);
                if (done) hits++;
            end
            check_val("R1", "done pulses without start", hits, 0);
        end
    endtask

    task automatic t_identity();
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                ma[r][c] = (r == c) ? 1 : 0;
                mb[r][c] = r * 4 + c;
            end
        load_mats();
        run_matmul(0, 0);
        check_results("R2 R3 identity");
    endtask

    task automatic t_wrap();
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                ma[r][c] = 15;
                mb[r][c] = 15;
            end
        load_mats();
        run_matmul(0, 0);
        check_results("R3 wrap");
    endtask

    task automatic t_general();
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                ma[r][c] = (r * 5 + c * 3 + 1) % 16;
                mb[r][c] = (r * 7 + c * 2 + 3) % 16;
            end
        load_mats();
        run_matmul(0, 0);
        check_results("R2 R4 general");
    endtask

    task automatic t_host_write_ignored();
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                ma[r][c] = (r * 3 + c + 2) % 16;
                mb[r][c] = (13 - r * 2 - c + 16) % 16;
            end
        load_mats();
        run_matmul(1, 0);
        check_results("R7 during run");
        run_matmul(0, 0);
        check_results("R7 memories kept");
    endtask

    task automatic t_start_ignored();
        run_matmul(0, 1);
        begin
            int hits = 0;
            for (int c = 0; c < 200; c++) begin
                @(negedge clk);
                if (done) hits++;
            end
            check_val("R8", "extra done pulses", hits, 0);
        end
        check_results("R8 results");
    endtask

    task automatic t_back_to_back();
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                ma[r][c] = (r + c * 4 + 5) % 16;
                mb[r][c] = (r * c + 9) % 16;
            end
        load_mats();
        run_matmul(0, 0);
        run_matmul(0, 0);
        check_results("R9 back-to-back");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R5 watchdog actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_identity();
        t_wrap();
        t_general();
        t_host_write_ignored();
        t_start_ignored();
        t_back_to_back();
        finished = 1;
        report();
        $finish;
    end
endmodule